// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block decides, every cycle, how a five-stage integer pipeline (fetch, decode with register read, execute, memory, write-back) keeps its results correct. Operands are read in decode and written in write-back, so the only data hazard is a read that comes before a pending write. The block removes most of those hazards by choosing, for each ALU operand in execute, whether it comes from the register file, from the memory-stage result register or from the write-back result register.

Where forwarding cannot help, the block interlocks. A load in execute whose destination is read by the instruction in decode holds the program counter and the fetch/decode register for one cycle and injects a no-op into the decode/execute register. The forwarding path from the write-back stage then delivers the loaded value. Branches resolve in decode. A taken branch squashes the single instruction fetched behind it, so the branch costs one cycle.

Two one-bit records let the unit recognise the slots it has itself voided. One marks that execute holds an injected bubble. The other marks that decode holds a squashed fetch. Control inputs that describe those slots are ignored, so a load produces exactly one bubble and a squashed slot can neither stall nor redirect.

Top module: `hz_unit`

## Requirements
- R1: While reset is asserted, and for two clock edges after it is released, stall, bubble and flush are 0 and both forwarding selects are 00. Both records are cleared.
- R2: An ALU operand selects the memory stage (select 10) when its source register is nonzero and matches the destination of a memory-stage instruction that has write-enable set and is not a load.
- R3: An ALU operand selects the write-back stage (select 01) when its source register is nonzero, matches the destination of a write-back instruction that has write-enable set, and does not select the memory stage.
- R4: When both the memory and write-back stages qualify for the same operand, select 10 wins.
- R5: Register 0 is never forwarded (select 00) and a load targeting register 0 never stalls.
- R6: A load in execute with write-enable set and a nonzero destination that equals either decode source raises stall and bubble together, in the same cycle as the match.
- R7: In the cycle after a bubble is injected, the execute-stage inputs are ignored, so a load-use match that is still presented raises no stall.
- R8: A taken branch in decode raises flush unless a stall is raised in the same cycle. In that case flush stays 0.
- R9: In the cycle after a flush, the decode slot is a no-op. Branch-taken and the decode sources are ignored, so neither flush nor stall is raised.
- R10: Forwarding selects for the two operands are decided independently of each other and of the stall, bubble and flush outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs1 | input | 5 | First source register of the decode instruction |
| id_rs2 | input | 5 | Second source register of the decode instruction |
| id_br_taken | input | 1 | Branch in decode resolved taken |
| ex_rs1 | input | 5 | First source register of the execute instruction |
| ex_rs2 | input | 5 | Second source register of the execute instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| ex_rd | input | 5 | Destination of the execute instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_rd | input | 5 | Destination of the memory-stage instruction |
| wb_we | input | 1 | Write-back instruction writes a register |
| wb_rd | input | 5 | Destination of the write-back instruction |
| fwd_a | output | 2 | Operand A source: 00 register file, 01 write-back, 10 memory stage |
| fwd_b | output | 2 | Operand B source, same encoding |
| stall | output | 1 | Hold program counter and fetch/decode register |
| bubble | output | 1 | Inject a no-op into the decode/execute register |
| flush | output | 1 | Turn the fetch/decode instruction into a no-op |

## Verification
A load-use interlock and a taken branch can arrive in the same cycle when the branch reads the loaded register. The bench provokes this directly by presenting a taken branch together with a matching load in execute. It expects stall and bubble with flush held low, and then expects the same branch to flush on the following cycle once execute holds the bubble. Random traffic over a four-register window makes such collisions, and collisions of both records with fresh hazards, frequent. A bench model tracks the two records from its own expected outputs and judges every cycle against them.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_rst_sync.sv
module hz_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] src,
  input  logic          mem_we,
  input  logic          mem_ld,
  input  logic [AW-1:0] mem_rd,
  input  logic          wb_we,
  input  logic [AW-1:0] wb_rd,
  output fwd_sel_e      sel
);
  logic src_live;
  logic mem_hit;
  logic wb_hit;

  always_comb begin
    src_live = (src != '0);
    // a load's data is not in the memory-stage result register yet
    mem_hit  = src_live && mem_we && !mem_ld && (mem_rd == src);
    wb_hit   = src_live && wb_we && (wb_rd == src);
    if (mem_hit)     sel = FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end

  assert_zero_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (sel == FWD_RF));
  assert_wb_needs_writer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == FWD_WB) |-> (wb_we && wb_rd == src));
  assert_mem_beats_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == FWD_WB) |-> !(mem_we && !mem_ld && mem_rd == src));
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int AW      = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][AW-1:0] id_src,
  input  logic                       ex_we,
  input  logic                       ex_ld,
  input  logic [AW-1:0]              ex_rd,
  output logic                       raw_hit
);
  logic [NUM_SRC-1:0] src_match;
  logic               producer_live;

  assign producer_live = ex_we && ex_ld && (ex_rd != '0);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign src_match[g] = (id_src[g] == ex_rd);
  end

  assign raw_hit = producer_live && (|src_match);
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_hit,
  input  logic br_taken,
  output logic stall,
  output logic bubble,
  output logic flush
);
  logic ex_void_q, ex_void_d;
  logic id_void_q, id_void_d;
  logic rec_en;

  always_comb begin
    stall     = rst_n && raw_hit && !ex_void_q && !id_void_q;
    bubble    = stall;
    flush     = rst_n && br_taken && !id_void_q && !stall;
    ex_void_d = bubble;
    id_void_d = flush;
    rec_en    = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_void_q <= 1'b0;
      id_void_q <= 1'b0;
    end else if (rec_en) begin
      ex_void_q <= ex_void_d;
      id_void_q <= id_void_d;
    end
  end

  assert_stall_with_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> bubble);
  assert_single_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> !bubble);
  assert_stall_blocks_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !flush);
  assert_quiet_after_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!flush && !stall));
endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
#(
  parameter int AW      = 5,
  parameter int NUM_SRC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_br_taken,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic          ex_we,
  input  logic          ex_load,
  input  logic [AW-1:0] ex_rd,
  input  logic          mem_we,
  input  logic          mem_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          wb_we,
  input  logic [AW-1:0] wb_rd,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          stall,
  output logic          bubble,
  output logic          flush
);
  logic                       rst_int_n;
  logic [NUM_SRC-1:0][AW-1:0] id_src;
  logic [NUM_SRC-1:0][AW-1:0] ex_src;
  fwd_sel_e [NUM_SRC-1:0]     sel;
  logic                       raw_hit;

  assign id_src = {id_rs2, id_rs1};
  assign ex_src = {ex_rs2, ex_rs1};

  hz_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_fwd
    hz_fwd_sel #(.AW(AW)) u_sel (
      .clk(clk), .rst_n(rst_int_n), .src(ex_src[g]),
      .mem_we(mem_we), .mem_ld(mem_load), .mem_rd(mem_rd),
      .wb_we(wb_we), .wb_rd(wb_rd), .sel(sel[g])
    );
  end

  hz_load_use #(.AW(AW), .NUM_SRC(NUM_SRC)) u_lu (
    .id_src(id_src), .ex_we(ex_we), .ex_ld(ex_load), .ex_rd(ex_rd),
    .raw_hit(raw_hit)
  );

  hz_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .raw_hit(raw_hit), .br_taken(id_br_taken),
    .stall(stall), .bubble(bubble), .flush(flush)
  );

  always_comb begin
    fwd_a = rst_int_n ? sel[0] : FWD_RF;
    fwd_b = rst_int_n ? sel[1] : FWD_RF;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_int_n |-> (!stall && !flush && fwd_a == 2'b00 && fwd_b == 2'b00));
endmodule

// File: tb/hz_unit_tb_top.sv
module hz_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic       id_br_taken, ex_we, ex_load, mem_we, mem_load, wb_we;
  logic [1:0] fwd_a, fwd_b;
  logic       stall, bubble, flush;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench model state
  logic m_exv = 0, m_idv = 0;
  int   rel_cnt = 0;
  logic e_stall = 0, e_flush = 0;

  always #2 clk = ~clk;

  hz_unit dut_i (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_br_taken(id_br_taken), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_we(ex_we), .ex_load(ex_load), .ex_rd(ex_rd),
    .mem_we(mem_we), .mem_load(mem_load), .mem_rd(mem_rd),
    .wb_we(wb_we), .wb_rd(wb_rd), .fwd_a(fwd_a), .fwd_b(fwd_b),
    .stall(stall), .bubble(bubble), .flush(flush)
  );

  always @(posedge clk) begin
    if (!rst_n || rel_cnt < 2) begin
      m_exv <= 1'b0;
      m_idv <= 1'b0;
    end else begin
      m_exv <= e_stall;
      m_idv <= e_flush;
    end
    if (!rst_n) rel_cnt <= 0;
    else if (rel_cnt < 2) rel_cnt <= rel_cnt + 1;
  end

  function automatic logic [1:0] exp_fwd(input logic [4:0] rs);
    if (rs != 0 && mem_we && !mem_load && mem_rd == rs) return 2'b10;
    if (rs != 0 && wb_we && wb_rd == rs) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string fwd_tag(input logic [1:0] e);
    return (e == 2'b10) ? "R2" : (e == 2'b01) ? "R3" : "R5";
  endfunction

  task automatic chk(input string tag, input string what, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [4:0] a1, a2, input logic br,
                       input logic [4:0] x1, x2, input logic xw, xl, input logic [4:0] xd,
                       input logic mw, ml, input logic [4:0] md, input logic ww, input logic [4:0] wd);
    @(negedge clk);
    id_rs1 = a1; id_rs2 = a2; id_br_taken = br;
    ex_rs1 = x1; ex_rs2 = x2; ex_we = xw; ex_load = xl; ex_rd = xd;
    mem_we = mw; mem_load = ml; mem_rd = md; wb_we = ww; wb_rd = wd;
    #1;
  endtask

  // checks all outputs against the model; tag overrides default tags when non-empty
  task automatic judge(input string tag);
    logic on;
    logic [1:0] ea, eb;
    logic es, ef;
    on = rst_n && (rel_cnt >= 2);
    ea = on ? exp_fwd(ex_rs1) : 2'b00;
    eb = on ? exp_fwd(ex_rs2) : 2'b00;
    es = on && !m_exv && !m_idv && ex_we && ex_load && ex_rd != 0 &&
         (ex_rd == id_rs1 || ex_rd == id_rs2);
    ef = on && !m_idv && id_br_taken && !es;
    e_stall = es;
    e_flush = ef;
    chk(tag != "" ? tag : fwd_tag(ea), "fwd_a", fwd_a, ea);
    chk(tag != "" ? tag : {fwd_tag(eb), "/R10"}, "fwd_b", fwd_b, eb);
    chk(tag != "" ? tag : "R6", "stall", {1'b0, stall}, {1'b0, es});
    chk(tag != "" ? tag : "R6", "bubble", {1'b0, bubble}, {1'b0, es});
    chk(tag != "" ? tag : "R8", "flush", {1'b0, flush}, {1'b0, ef});
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    id_rs1 = 0; id_rs2 = 0; id_br_taken = 0; ex_rs1 = 0; ex_rs2 = 0;
    ex_we = 0; ex_load = 0; ex_rd = 0; mem_we = 0; mem_load = 0; mem_rd = 0;
    wb_we = 0; wb_rd = 0;
    // R1: hazards presented while reset is held
    drive(5'd3, 5'd4, 1, 5'd3, 5'd3, 1, 1, 5'd3, 1, 0, 5'd3, 1, 5'd3);
    judge("R1");
    drive(5'd3, 5'd4, 1, 5'd3, 5'd3, 1, 1, 5'd3, 1, 0, 5'd3, 1, 5'd3);
    judge("R1");
    @(negedge clk); rst_n = 1;
    drive(0,0,0, 0,0,0,0,0, 0,0,0, 0,0);
    judge("R1");
    drive(0,0,0, 0,0,0,0,0, 0,0,0, 0,0);
    judge("R1");
    // R4: both later stages write the operand's register
    drive(0,0,0, 5'd7, 5'd9, 0,0,0, 1,0,5'd7, 1,5'd7);
    judge("R4");
    // R3: memory stage holds a load of the same register -> write-back path
    drive(0,0,0, 5'd7, 5'd7, 0,0,0, 1,1,5'd7, 1,5'd7);
    judge("R3");
    // R5: register 0 everywhere
    drive(0,0,0, 0,0, 1,1,0, 1,0,0, 1,0);
    judge("R5");
    // R6 then R7: same load-use match held for two cycles
    drive(5'd5, 5'd1, 0, 0,0, 1,1,5'd5, 0,0,0, 0,0);
    judge("R6");
    drive(5'd5, 5'd1, 0, 0,0, 1,1,5'd5, 0,0,0, 0,0);
    judge("R7");
    // R8: taken branch reading the loaded register -> stall wins
    drive(5'd2, 5'd6, 1, 0,0, 1,1,5'd6, 0,0,0, 0,0);
    judge("R8");
    // bubble now in execute: branch resolves and flushes
    drive(5'd2, 5'd6, 1, 0,0, 1,1,5'd6, 1,1,5'd6, 0,0);
    judge("R8");
    // R9: squashed decode slot ignores branch and load-use match
    drive(5'd2, 5'd6, 1, 0,0, 1,1,5'd6, 0,0,0, 0,0);
    judge("R9");
    drive(0,0,0, 0,0,0,0,0, 0,0,0, 0,0);
    judge("");
    // random traffic over a small register window
    for (int i = 0; i < 3000; i++) begin
      drive($urandom % 4, $urandom % 4, ($urandom % 4) == 0,
            $urandom % 4, $urandom % 4, ($urandom % 10) < 7, ($urandom % 3) == 0, $urandom % 4,
            ($urandom % 10) < 7, ($urandom % 3) == 0, $urandom % 4,
            ($urandom % 10) < 7, $urandom % 4);
      judge("");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule